// File: doc/BRIEF.md
# Strap-Selected Bus Target Address Latch

This block picks the 7-bit I2C target address of a device from a three-level strap pin. An outside pad detector turns the strap level into a 2-bit code. Until the address is committed, the block decodes that code on every cycle, and address comparison follows the live strap.

The block counts transactions that are addressed to the device. A transaction counts when the seven address bits that follow a start condition equal the address currently decoded. When the second such transaction reaches its eighth SCL rising edge, the block freezes the address it decoded in that cycle. From then on the strap has no effect, and only reset clears the frozen state.

The block takes single-cycle event strobes from the bus front end: start, stop and SCL rising edges. It also takes the contents of the front end's byte shifter. It drives the current address, a locked flag and a one-cycle address-match pulse. The rest of the target logic uses the match pulse to decide whether to acknowledge.

Top module: `strap_addr_latch`

## Requirements
- R1: Before lock, the output address decodes the strap code combinationally. Code 00 (low) gives 7'b1001000 (0x48), 01 (floating) gives 7'b1001010 (0x4A), 10 (high) gives 7'b1001011 (0x4B), and 11 gives 0x48.
- R2: After reset, `addr_locked` is 0 and the count of valid transactions is 0.
- R3: `addr_match` is high only in the cycle of the eighth `scl_rise` after a start, and only when `shift_byte[7:1]` equals `dev_addr` in that cycle. It is never high on any other edge, including the ninth.
- R4: A single valid transaction does not lock the address.
- R5: On the eighth edge of the second valid transaction, `addr_locked` rises and is visible the following cycle. It then stays high until reset.
- R6: A transaction whose address bits differ from the decoded address produces no match and does not advance the count.
- R7: Once locked, `dev_addr` holds the latched value whatever the strap code does.
- R8: A stop ends the frame. SCL edges after a stop, with no new start, produce no match.
- R9: A start that arrives inside a frame restarts the bit count from zero.
- R10: The R/W bit (`shift_byte[0]`) is left out of the comparison.
- R11: The latched address is the one decoded from the strap in the same cycle as the locking edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_code | input | 2 | Encoded strap level: 00 low, 01 floating, 10 high |
| start_det | input | 1 | One-cycle strobe for a start or repeated start |
| stop_det | input | 1 | One-cycle strobe for a stop condition |
| scl_rise | input | 1 | One-cycle strobe for an SCL rising edge |
| shift_byte | input | 8 | Byte shifter contents; address in [7:1], R/W in [0] |
| dev_addr | output | 7 | Current target address |
| addr_locked | output | 1 | Address has been latched |
| addr_match | output | 1 | Address matched on this eighth edge |

## Verification
The critical overlap is a strap change that lands in the same cycle as the eighth edge of the locking transaction. In that cycle the comparison and the capture both have to use the new decode. The bench changes the strap code from floating to high exactly on the cycle that carries the eighth edge of the second valid frame, and sends address 0x4B in that frame. It then expects one match pulse, a lock on the next cycle, and `dev_addr` held at 0x4B when the strap is later moved back to low. This same frame also opens with an aborted prefix that is cut short by a repeated start, so the restarted bit count and the lock are judged together.

// File: rtl/strap_addr_pkg.sv
package strap_addr_pkg;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] ADDR_BASE = 7'b1001000;

  typedef enum logic [1:0] {
    STRAP_LOW   = 2'b00,
    STRAP_FLOAT = 2'b01,
    STRAP_HIGH  = 2'b10,
    STRAP_RSVD  = 2'b11
  } strap_e;

  // Strap level to target address; the reserved code falls back to low.
  function automatic logic [ADDR_W-1:0] strap_to_addr(input logic [1:0] code);
    logic [ADDR_W-1:0] a;
    case (strap_e'(code))
      STRAP_FLOAT: a = ADDR_BASE + ADDR_W'(2);
      STRAP_HIGH:  a = ADDR_BASE + ADDR_W'(3);
      default:     a = ADDR_BASE;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/strap_decoder.sv
module strap_decoder
  import strap_addr_pkg::*;
(
  input  logic [1:0]        strap_code,
  output logic [ADDR_W-1:0] live_addr
);
  always_comb live_addr = strap_to_addr(strap_code);
endmodule

// File: rtl/frame_bit_counter.sv
module frame_bit_counter #(
  parameter int FRAME_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_rise,
  output logic last_edge
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic          active_q;
  logic [CW-1:0] bits_q;

  always_comb
    last_edge = active_q && scl_rise && !start_det && !stop_det &&
                (bits_q == CW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bits_q   <= '0;
    end else if (start_det) begin
      active_q <= 1'b1;
      bits_q   <= '0;
    end else if (stop_det) begin
      active_q <= 1'b0;
      bits_q   <= '0;
    end else if (active_q && scl_rise) begin
      bits_q <= bits_q + CW'(1);
      if (bits_q == CW'(FRAME_BITS - 1)) active_q <= 1'b0;
    end
  end

  // R3
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (bits_q < CW'(FRAME_BITS)));
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import strap_addr_pkg::*;
#(
  parameter int LOCK_AFTER = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [ADDR_W-1:0] live_addr,
  output logic              locked,
  output logic [ADDR_W-1:0] held_addr
);
  localparam int CW = $clog2(LOCK_AFTER + 1);

  logic [CW-1:0] seen_q;
  logic          commit;

  always_comb commit = hit && !locked && (seen_q == CW'(LOCK_AFTER - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= '0;
      locked    <= 1'b0;
      held_addr <= '0;
    end else if (!locked && hit) begin
      if (commit) begin
        locked    <= 1'b1;
        held_addr <= live_addr;
      end else begin
        seen_q <= seen_q + CW'(1);
      end
    end
  end

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R5
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit));
  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (seen_q < CW'(LOCK_AFTER)));
endmodule

// File: rtl/strap_addr_latch.sv
module strap_addr_latch
  import strap_addr_pkg::*;
#(
  parameter int LOCK_AFTER = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_code,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic [7:0]        shift_byte,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              addr_locked,
  output logic              addr_match
);
  localparam int FRAME_BITS = ADDR_W + 1;

  logic [ADDR_W-1:0] live_addr;
  logic [ADDR_W-1:0] held_addr;
  logic              eighth_edge;
  logic              addr_equal;

  strap_decoder u_dec (
    .strap_code (strap_code),
    .live_addr  (live_addr)
  );

  frame_bit_counter #(.FRAME_BITS(FRAME_BITS)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .last_edge (eighth_edge)
  );

  always_comb begin
    dev_addr   = addr_locked ? held_addr : live_addr;
    addr_equal = (shift_byte[7:1] == dev_addr);
    addr_match = eighth_edge && addr_equal;
  end

  lock_ctrl #(.LOCK_AFTER(LOCK_AFTER)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (addr_match),
    .live_addr (live_addr),
    .locked    (addr_locked),
    .held_addr (held_addr)
  );

  // R7
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_locked && $past(addr_locked)) |-> $stable(dev_addr));
  // R3
  match_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> scl_rise);
  // R11
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_locked) |-> (dev_addr == $past(live_addr)));
endmodule

// File: tb/test_strap_addr_latch.sv
`timescale 1ns/1ps
module test_strap_addr_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_code = 2'b00;
  logic       start_det = 1'b0, stop_det = 1'b0, scl_rise = 1'b0;
  logic [7:0] shift_byte = 8'h00;
  logic [6:0] dev_addr;
  logic       addr_locked, addr_match;

  int checks = 0, fails = 0;
  logic [6:0] exp_q[$];

  always #4 clk = ~clk;

  strap_addr_latch i_strap_addr_latch (
    .clk(clk), .rst_n(rst_n), .strap_code(strap_code),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise),
    .shift_byte(shift_byte), .dev_addr(dev_addr),
    .addr_locked(addr_locked), .addr_match(addr_match));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every observed match pulse consumes one expected address.
  always @(negedge clk) begin
    if (rst_n && addr_match) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 actual=match expected=no match (addr %0h)", dev_addr);
      end else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        if (dev_addr !== e) begin
          fails++;
          $display("FAIL R3 actual=%0h expected=%0h", dev_addr, e);
        end
      end
    end
  end

  function automatic logic [6:0] model_addr(input logic [1:0] c);
    return (c == 2'b01) ? 7'h4A : (c == 2'b10) ? 7'h4B : 7'h48;
  endfunction

  task automatic tick; @(posedge clk); #1; endtask

  task automatic clear_strobes;
    start_det = 0; stop_det = 0; scl_rise = 0;
  endtask

  // Shift n edges; on the last of them the shifter shows the full byte.
  task automatic edges(input int n, input logic [7:0] b);
    for (int i = 1; i <= n; i++) begin
      scl_rise = 1; shift_byte = b >> (8 - i); tick(); scl_rise = 0;
    end
  endtask

  // Full frame: start, 8 edges, a ninth (ack) edge, stop.
  task automatic frame(input logic [7:0] b, input bit expect_hit, input logic [6:0] ea);
    start_det = 1; tick(); clear_strobes();
    if (expect_hit) exp_q.push_back(ea);
    edges(8, b);
    scl_rise = 1; tick(); scl_rise = 0;
    stop_det = 1; tick(); clear_strobes(); tick();
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    repeat (3) tick();
    rst_n = 1; tick();
    @(negedge clk);
    check("R2 locked after reset", addr_locked, 0);
    for (int c = 0; c < 4; c++) begin
      strap_code = 2'(c); #1;
      check("R1 strap decode", dev_addr, model_addr(2'(c)));
    end
    tick();

    strap_code = 2'b01; tick();
    // R6: address for a different strap
    frame({7'h48, 1'b0}, 0, 0);
    check("R6 no lock after mismatch", addr_locked, 0);
    // R10: R/W = 1 still matches; R4: first valid does not lock
    frame({7'h4A, 1'b1}, 1, 7'h4A);
    @(negedge clk);
    check("R4 single valid no lock", addr_locked, 0);
    check("R3 pulses consumed", exp_q.size(), 0);

    // R8: stop mid frame, further edges without start must not match
    start_det = 1; tick(); clear_strobes();
    edges(4, {7'h4A, 1'b0});
    stop_det = 1; tick(); clear_strobes();
    edges(8, {7'h4A, 1'b0});
    tick(); @(negedge clk);
    check("R8 no lock after aborted frame", addr_locked, 0);

    // R9 + R11: repeated start, strap moves to high on the eighth edge
    start_det = 1; tick(); clear_strobes();
    edges(3, {7'h4A, 1'b0});
    start_det = 1; tick(); clear_strobes();
    exp_q.push_back(7'h4B);
    edges(7, {7'h4B, 1'b0});
    strap_code = 2'b10; scl_rise = 1; shift_byte = {7'h4B, 1'b0}; tick(); scl_rise = 0;
    @(negedge clk);
    check("R5 locked on second valid", addr_locked, 1);
    check("R11 captured address", dev_addr, 7'h4B);
    check("R9 restarted frame matched", exp_q.size(), 0);
    stop_det = 1; tick(); clear_strobes();

    // R7: strap ignored after lock
    strap_code = 2'b00; tick(); @(negedge clk);
    check("R7 address frozen", dev_addr, 7'h4B);
    frame({7'h48, 1'b0}, 0, 0);
    frame({7'h4B, 1'b0}, 1, 7'h4B);
    @(negedge clk);
    check("R5 lock sticky", addr_locked, 1);
    check("R3 all matches seen", exp_q.size(), 0);

    // R2: reset alone clears the lock
    rst_n = 0; tick(); tick(); rst_n = 1; tick(); @(negedge clk);
    check("R2 lock cleared by reset", addr_locked, 0);
    check("R1 live decode after reset", dev_addr, 7'h48);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule